// File: doc/BRIEF.md
# Strobed Lookup Table Logic Section

This block is one programmable logic section. An 8-bit input vector addresses a 256-entry by 8-bit memory that the host fills through a simple write port, so any 8-in, 8-out logic function can be loaded. The looked-up byte, or a host-written output byte, drives the section outputs. A validity mode decides when that byte may appear on the outputs.

In normal mode the outputs follow the inputs at all times. In strobed mode a strobe edge freezes the address, and the outputs carry the looked-up byte only while the strobe stays high. Shaped mode also freezes on the edge, but the window lasts a fixed number of clocks. The strobe comes from an external pin or from a one-cycle host command. Both strobed and shaped windows begin with a one-clock sync pulse.

The external strobe is synchronized and edge-detected on the system clock. A state machine then runs the window. Its states are IDLE, STROBED and SHAPED, and it has these transitions:
- IDLE to STROBED (accept): a strobe edge is accepted in strobed mode.
- IDLE to SHAPED (accept): a strobe edge is accepted in shaped mode.
- STROBED to IDLE (release): the synchronized strobe is low, the window was opened by a software strobe, or normal mode is in force.
- SHAPED to IDLE (expire): the width counter has reached zero, or normal mode is in force.

Top module: `lut_logic_section`

## Requirements
- R1: A host write with `mem_we` high stores `mem_wdata` at `mem_waddr` on the clock edge. In normal mode with `addr_from_reg`=0 and `out_from_mem`=1, `out_vec` equals the stored byte at address `in_vec`, with no clock of delay.
- R2: `mode_sel` encodes the validity mode as 00 normal, 01 strobed, 10 shaped and 11 normal. In normal mode `out_vec` follows the current address with no delay, the strobes have no effect, `sync_out` stays 0, and `in_capture` equals `in_vec`.
- R3: With `strobe_dis`=1 the section behaves as in normal mode whatever `mode_sel` holds.
- R4: In strobed and shaped modes the address is frozen on the clock edge that accepts a strobe. Input changes during the window do not alter `out_vec`. `in_capture` holds the `in_vec` value taken on that same edge.
- R5: In strobed mode `out_vec` is 0 outside the window. `strobe_in` is synchronized through 2 flops and then edge-detected, so a rise that is first sampled at edge E makes the window visible after edge E+2. The window lasts as many clocks as `strobe_in` stayed high.
- R6: In shaped mode the window lasts exactly SHAPE_CYC clocks (default 5), whatever the strobe width. A strobe edge that arrives during the window is ignored.
- R7: `sync_out` is high for exactly one clock, in the first clock of each strobed or shaped window.
- R8: A one-cycle `sw_strobe` pulse, sampled at edge E, captures `in_vec` into `in_capture` and opens the window after edge E. In strobed mode that window lasts one clock.
- R9: With `addr_from_reg`=1 the memory address comes from the host address register, which is written by `areg_we`/`areg_wdata`, and not from `in_vec`.
- R10: With `out_from_mem`=0 the outputs carry the host output register, which is written by `oreg_we`/`oreg_wdata`, and not the memory data.
- R11: After reset the state is IDLE, `sync_out` is 0, and `in_capture`, the address register and the output register are all 0. In strobed mode `out_vec` is then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vec | input | 8 | External input vector |
| strobe_in | input | 1 | External strobe, asynchronous |
| sw_strobe | input | 1 | One-cycle software strobe command |
| mem_we | input | 1 | Memory write enable |
| mem_waddr | input | 8 | Memory write address |
| mem_wdata | input | 8 | Memory write data |
| areg_we | input | 1 | Address register write enable |
| areg_wdata | input | 8 | Address register write data |
| oreg_we | input | 1 | Output register write enable |
| oreg_wdata | input | 8 | Output register write data |
| mode_sel | input | 2 | Validity mode: 00 normal, 01 strobed, 10 shaped, 11 normal |
| strobe_dis | input | 1 | Forces normal mode when 1 |
| addr_from_reg | input | 1 | Address source: 0 inputs, 1 address register |
| out_from_mem | input | 1 | Output source: 1 memory, 0 output register |
| out_vec | output | 8 | Section outputs |
| sync_out | output | 1 | One-clock pulse at the start of a window |
| in_capture | output | 8 | Input capture register (transparent in normal mode) |

## Verification
The assertions check four things on every cycle:
- the sync pulse never lasts two clocks and only occurs inside a window;
- the frozen address stays stable for as long as a window is open;
- the shaped counter stays below its width, and a strobe that arrives during a shaped window never raises a sync;
- once normal mode has been in force for a clock, no window remains open.

Only the bench scenarios can show the following:
- the window lengths that result from a given strobe width and from SHAPE_CYC;
- the latency from the strobe to the output;
- the lookup values themselves;
- the effect of the two source selects and of the strobe-disable bit on the output.

// File: rtl/lutsec_pkg.sv
package lutsec_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL     = 2'b00,
        MODE_STROBED    = 2'b01,
        MODE_SHAPED     = 2'b10,
        MODE_NORMAL_ALT = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        WS_IDLE    = 2'b00,
        WS_STROBED = 2'b01,
        WS_SHAPED  = 2'b10
    } win_state_e;

endpackage

// File: rtl/lutsec_edge.sv
module lutsec_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic lvl,
    output logic rise
);
    localparam int unsigned CHAIN_W = STAGES + 1;

    // chain_q[0..STAGES-1] is the synchronizer; the top bit is the edge reference
    logic [CHAIN_W-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], async_in};
        end
    end

    assign lvl  = chain_q[STAGES-1];
    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/lutsec_mem.sv
module lutsec_mem #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // asynchronous read keeps the lookup path free of a pipeline stage
    assign rdata = cells[raddr];

endmodule

// File: rtl/lutsec_window.sv
module lutsec_window
    import lutsec_pkg::*;
#(
    parameter int unsigned AW        = 8,
    parameter int unsigned CNT_W     = 4,
    parameter int unsigned SHAPE_CYC = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gated_en,
    input  logic          shaped_sel,
    input  logic          ext_rise,
    input  logic          ext_lvl,
    input  logic          sw_trig,
    input  logic [AW-1:0] addr_in,
    output logic          accept,
    output logic          win_active,
    output logic          sync_pulse,
    output logic [AW-1:0] cap_addr
);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SHAPE_CYC - 1);

    win_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [AW-1:0]    cap_q, cap_d;
    logic             sw_q, sw_d;
    logic             sync_q;

    assign accept = (state_q == WS_IDLE) && gated_en && (ext_rise || sw_trig);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        cap_d   = cap_q;
        sw_d    = sw_q;
        unique case (state_q)
            WS_IDLE: begin
                if (accept) begin
                    state_d = shaped_sel ? WS_SHAPED : WS_STROBED;
                    cap_d   = addr_in;
                    cnt_d   = CNT_LOAD;
                    sw_d    = sw_trig & ~ext_rise;
                end
            end
            WS_STROBED: begin
                if (!gated_en || sw_q || !ext_lvl) begin
                    state_d = WS_IDLE;
                end
            end
            WS_SHAPED: begin
                if (!gated_en || (cnt_q == '0)) begin
                    state_d = WS_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = WS_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
            cnt_q   <= '0;
            cap_q   <= '0;
            sw_q    <= 1'b0;
            sync_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            cap_q   <= cap_d;
            sw_q    <= sw_d;
            sync_q  <= accept;
        end
    end

    // outputs
    always_comb begin
        win_active = (state_q != WS_IDLE);
        sync_pulse = sync_q;
        cap_addr   = cap_q;
    end

    // R7: sync never lasts two clocks
    a_r7_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
        sync_q |=> !sync_q);

    // R7: sync only in the first clock of an open window
    a_r7_sync_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        sync_q |-> (state_q != WS_IDLE));

    // R4: frozen address stays stable while the window is open
    a_r4_cap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != WS_IDLE) && $past(state_q != WS_IDLE)) |-> $stable(cap_q));

    // R6: shaped counter never exceeds the programmed width
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_SHAPED) |-> (cnt_q < CNT_W'(SHAPE_CYC)));

    // R6: a strobe arriving in an open shaped window raises no sync
    a_r6_retrig_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == WS_SHAPED) && (cnt_q != '0) && gated_en && (ext_rise || sw_trig))
        |=> !sync_q);

endmodule

// File: rtl/lut_logic_section.sv
module lut_logic_section
    import lutsec_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CNT_W       = 4,
    parameter int unsigned SHAPE_CYC   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] in_vec,
    input  logic              strobe_in,
    input  logic              sw_strobe,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_waddr,
    input  logic [DATA_W-1:0] mem_wdata,
    input  logic              areg_we,
    input  logic [ADDR_W-1:0] areg_wdata,
    input  logic              oreg_we,
    input  logic [DATA_W-1:0] oreg_wdata,
    input  logic [1:0]        mode_sel,
    input  logic              strobe_dis,
    input  logic              addr_from_reg,
    input  logic              out_from_mem,
    output logic [DATA_W-1:0] out_vec,
    output logic              sync_out,
    output logic [ADDR_W-1:0] in_capture
);
    mode_e             mode;
    logic              eff_normal;
    logic              shaped_sel;
    logic              ext_lvl, ext_rise;
    logic              accept, win_active, sync_pulse;
    logic [ADDR_W-1:0] cap_addr, live_addr, rd_addr;
    logic [ADDR_W-1:0] areg_q, inreg_q;
    logic [DATA_W-1:0] oreg_q, mem_rdata, src_data;

    assign mode       = mode_e'(mode_sel);
    assign eff_normal = strobe_dis || !((mode == MODE_STROBED) || (mode == MODE_SHAPED));
    assign shaped_sel = (mode == MODE_SHAPED);

    lutsec_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (strobe_in),
        .lvl      (ext_lvl),
        .rise     (ext_rise)
    );

    assign live_addr = addr_from_reg ? areg_q : in_vec;

    lutsec_window #(
        .AW        (ADDR_W),
        .CNT_W     (CNT_W),
        .SHAPE_CYC (SHAPE_CYC)
    ) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .gated_en   (!eff_normal),
        .shaped_sel (shaped_sel),
        .ext_rise   (ext_rise),
        .ext_lvl    (ext_lvl),
        .sw_trig    (sw_strobe),
        .addr_in    (live_addr),
        .accept     (accept),
        .win_active (win_active),
        .sync_pulse (sync_pulse),
        .cap_addr   (cap_addr)
    );

    assign rd_addr = eff_normal ? live_addr : cap_addr;

    lutsec_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (mem_rdata)
    );

    // host registers and input capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            areg_q  <= '0;
            oreg_q  <= '0;
            inreg_q <= '0;
        end else begin
            if (areg_we) areg_q  <= areg_wdata;
            if (oreg_we) oreg_q  <= oreg_wdata;
            if (accept)  inreg_q <= in_vec;
        end
    end

    assign src_data = out_from_mem ? mem_rdata : oreg_q;

    always_comb begin
        if (eff_normal) begin
            out_vec    = src_data;
            sync_out   = 1'b0;
            in_capture = in_vec;
        end else begin
            out_vec    = win_active ? src_data : '0;
            sync_out   = sync_pulse;
            in_capture = inreg_q;
        end
    end

    // R2 / R3: after a clock of normal mode no window is left open
    a_r2_normal_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_normal && $past(eff_normal)) |-> !win_active);

    // R8: a software strobe in an idle gated mode always opens a window
    a_r8_sw_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_strobe && !eff_normal && !win_active) |=> (win_active && sync_pulse));

endmodule

// File: tb/tb_lut_logic_section.sv
module tb_lut_logic_section;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] in_vec;
    logic       strobe_in, sw_strobe;
    logic       mem_we;
    logic [7:0] mem_waddr, mem_wdata;
    logic       areg_we;
    logic [7:0] areg_wdata;
    logic       oreg_we;
    logic [7:0] oreg_wdata;
    logic [1:0] mode_sel;
    logic       strobe_dis, addr_from_reg, out_from_mem;
    logic [7:0] out_vec;
    logic       sync_out;
    logic [7:0] in_capture;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    localparam int SHAPE = 5;

    always #2 clk = ~clk;

    lut_logic_section dut (
        .clk(clk), .rst_n(rst_n), .in_vec(in_vec), .strobe_in(strobe_in),
        .sw_strobe(sw_strobe), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata), .areg_we(areg_we), .areg_wdata(areg_wdata),
        .oreg_we(oreg_we), .oreg_wdata(oreg_wdata), .mode_sel(mode_sel),
        .strobe_dis(strobe_dis), .addr_from_reg(addr_from_reg),
        .out_from_mem(out_from_mem), .out_vec(out_vec), .sync_out(sync_out),
        .in_capture(in_capture)
    );

    function automatic logic [7:0] f(input logic [7:0] a);
        return {a[3:0], a[7:4]} ^ 8'h3C;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic t_reset();
        tick();
        chk("R11 out_vec after reset", out_vec, 0);
        chk("R11 sync after reset", sync_out, 0);
        chk("R11 in_capture after reset", in_capture, 0);
    endtask

    task automatic t_program();
        for (int a = 0; a < 256; a++) begin
            mem_we = 1'b1; mem_waddr = 8'(a); mem_wdata = f(8'(a));
            tick();
        end
        mem_we = 1'b0;
        mode_sel = 2'b00;
        in_vec = 8'h00; #1 chk("R1 lookup 00", out_vec, f(8'h00));
        in_vec = 8'hFF; #1 chk("R1 lookup FF", out_vec, f(8'hFF));
        in_vec = 8'h81; #1 chk("R1 lookup 81", out_vec, f(8'h81));
        tick();
    endtask

    task automatic t_normal();
        int syncs = 0;
        int bad = 0;
        mode_sel = 2'b00;
        for (int i = 0; i < 10; i++) begin
            in_vec = 8'(i * 37 + 1);
            strobe_in = i[0];
            tick();
            if (sync_out) syncs++;
            if (out_vec != f(in_vec)) bad++;
            if (in_capture != in_vec) bad++;
        end
        strobe_in = 1'b0;
        chk("R2 normal no sync", syncs, 0);
        chk("R2 normal follows and capture transparent", bad, 0);
        mode_sel = 2'b11;
        in_vec = 8'h4E; #1 chk("R2 mode 11 is normal", out_vec, f(8'h4E));
        mode_sel = 2'b00;
        tick();
    endtask

    task automatic t_disable();
        int syncs = 0;
        mode_sel = 2'b01; strobe_dis = 1'b1;
        in_vec = 8'h39; #1 chk("R3 disable forces normal", out_vec, f(8'h39));
        strobe_in = 1'b1;
        for (int i = 0; i < 6; i++) begin
            tick();
            if (sync_out) syncs++;
        end
        strobe_in = 1'b0;
        chk("R3 disabled strobe no sync", syncs, 0);
        chk("R3 disabled capture transparent", in_capture, 8'h39);
        repeat (4) tick();
        strobe_dis = 1'b0;
        tick();
    endtask

    task automatic t_strobed();
        int act = 0, syncs = 0, bad = 0, first = -1, sync_at = -1;
        mode_sel = 2'b01;
        tick();
        chk("R5 idle strobed zero", out_vec, 0);
        in_vec = 8'h17; strobe_in = 1'b1;
        for (int i = 1; i <= 12; i++) begin
            tick();
            if (out_vec != 0) begin
                act++;
                if (first < 0) first = i;
                if (out_vec != f(8'h17)) bad++;
            end
            if (sync_out) begin syncs++; sync_at = i; end
            if (i == 3) in_vec = 8'hE2;
            if (i == 4) strobe_in = 1'b0;
        end
        chk("R5 window length equals strobe width", act, 4);
        chk("R5 window starts after two sync stages", first, 3);
        chk("R4 frozen value during window", bad, 0);
        chk("R4 in_capture frozen", in_capture, 8'h17);
        chk("R7 one sync per window", syncs, 1);
        chk("R7 sync in first window cycle", sync_at, first);
        chk("R5 zero after window", out_vec, 0);
    endtask

    task automatic t_shaped(input int hold, input bit retrig);
        int act = 0, syncs = 0, bad = 0;
        mode_sel = 2'b10;
        tick();
        in_vec = 8'h2B; strobe_in = 1'b1;
        for (int i = 1; i <= 16; i++) begin
            tick();
            if (out_vec != 0) begin
                act++;
                if (out_vec != f(8'h2B)) bad++;
            end
            if (sync_out) syncs++;
            if (i == hold) strobe_in = 1'b0;
            if (retrig && i == 3) begin strobe_in = 1'b1; in_vec = 8'h90; end
            if (retrig && i == 4) strobe_in = 1'b0;
        end
        strobe_in = 1'b0;
        chk("R6 shaped width fixed", act, SHAPE);
        chk("R6 shaped value frozen", bad, 0);
        chk("R6 retrigger ignored, single sync", syncs, 1);
    endtask

    task automatic t_sw(input logic [1:0] m, input int exp_len);
        int act = 0, first = -1, syncs = 0;
        mode_sel = m;
        tick();
        in_vec = 8'h64; sw_strobe = 1'b1;
        for (int i = 1; i <= 10; i++) begin
            tick();
            if (out_vec != 0) begin act++; if (first < 0) first = i; end
            if (sync_out) syncs++;
            if (i == 1) begin sw_strobe = 1'b0; in_vec = 8'h0F; end
        end
        chk("R8 software strobe window length", act, exp_len);
        chk("R8 software strobe window opens next cycle", first, 1);
        chk("R8 software strobe capture", in_capture, 8'h64);
        chk("R7 software strobe single sync", syncs, 1);
    endtask

    task automatic t_addr_sel();
        mode_sel = 2'b00; addr_from_reg = 1'b1;
        areg_we = 1'b1; areg_wdata = 8'h91;
        tick();
        areg_we = 1'b0;
        in_vec = 8'h05; #1 chk("R9 address register source", out_vec, f(8'h91));
        in_vec = 8'hB6; #1 chk("R9 inputs ignored", out_vec, f(8'h91));
        addr_from_reg = 1'b0;
        tick();
    endtask

    task automatic t_out_sel();
        mode_sel = 2'b00; out_from_mem = 1'b0;
        oreg_we = 1'b1; oreg_wdata = 8'hA7;
        tick();
        oreg_we = 1'b0;
        in_vec = 8'h12; #1 chk("R10 output register source", out_vec, 8'hA7);
        in_vec = 8'h77; #1 chk("R10 memory ignored", out_vec, 8'hA7);
        out_from_mem = 1'b1;
        tick();
    endtask

    initial begin
        rst_n = 1'b0; in_vec = 8'h00; strobe_in = 1'b0; sw_strobe = 1'b0;
        mem_we = 1'b0; mem_waddr = '0; mem_wdata = '0;
        areg_we = 1'b0; areg_wdata = '0; oreg_we = 1'b0; oreg_wdata = '0;
        mode_sel = 2'b01; strobe_dis = 1'b0; addr_from_reg = 1'b0; out_from_mem = 1'b1;
        repeat (3) tick();
        rst_n = 1'b1;
        t_reset();
        t_program();
        t_normal();
        t_disable();
        t_strobed();
        t_shaped(2, 1'b1);
        t_shaped(9, 1'b0);
        t_sw(2'b01, 1);
        t_sw(2'b10, SHAPE);
        t_addr_sel();
        t_out_sel();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule